// File: doc/BRIEF.md
# Bit-count integer ALU

This block is the integer execution unit of a small RISC core. It selects one of sixteen operations with a 4-bit code and applies it to a 32-bit operand A and a 32-bit operand B. The result comes out in the same cycle, together with a carry flag and a zero flag. Operand B comes from the register port or from a 16-bit immediate that is zero-extended. One input flag chooses between the two, so the register-register and register-immediate instruction forms share one datapath.

The unit has the usual add, subtract, shift, rotate and bitwise logic operations. It also has three bit-count operations and a pseudo-random source. The bit-count operations report how many bits of A are set, how many are clear, and how many neighbouring bit pairs of A differ. The random source is a 32-bit Galois LFSR. It is the only state in the unit and it steps once for each clock edge that sees the random operation selected.

Top module: `alu_core`

## Requirements
- R1: Code 0 (add) gives A + B modulo 2^32, and carry is the carry out of bit 31.
- R2: Code 1 (subtract) gives A - B modulo 2^32. Carry is 1 exactly when A >= B as unsigned numbers, so carry is the inverted borrow.
- R3: While use_imm_i is 1, operand B is {16'h0000, imm_i} for every operation and b_i has no effect. While use_imm_i is 0, operand B is b_i.
- R4: Code 2 is a logical right shift and code 3 is a logical left shift. Both shift A by B[4:0] and fill with zeros. B[31:5] is ignored.
- R5: Code 4 rotates A right by B[4:0] and code 5 rotates A left by B[4:0]. An amount of 0 returns A unchanged.
- R6: Code 6 gives the number of 1 bits in A, from 0 to 32.
- R7: Code 7 gives the number of 0 bits in A, from 0 to 32.
- R8: Code 8 gives the number of positions i in 0..30 where A[i] differs from A[i+1], from 0 to 31.
- R9: Code 9 gives the current LFSR state. Reset loads the state with 32'h1D87_2B41. Each rising clock edge with code 9 selected replaces the state s with (s >> 1) XOR (s[0] ? 32'h8020_0003 : 0). With any other code the state holds, and it is never zero.
- R10: Code 10 gives A OR B, code 11 gives A AND B, code 12 gives A XOR B, and code 13 gives NOT A.
- R11: Codes 14 and 15 are reserved and give a result of 0.
- R12: Zero is 1 exactly when the result is all zeros, for every code. Carry is 0 for every code except 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the LFSR |
| rst_n | input | 1 | Asynchronous reset, active low; loads the LFSR seed |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Register operand B |
| imm_i | input | 16 | Immediate operand, zero-extended |
| use_imm_i | input | 1 | 1 selects the immediate as operand B |
| res_o | output | 32 | Result |
| carry_o | output | 1 | Carry out on add, inverted borrow on subtract, otherwise 0 |
| zero_o | output | 1 | Result is all zeros |

## Verification
The arithmetic cases include operand pairs that wrap to zero, that borrow, and that are equal. These separate a true carry out from an inverted borrow and from the zero flag. Some shift and rotate amounts set bits above bit 4, and one amount is 0. These show whether the amount is masked and whether rotate differs from shift. The bit-count cases use all ones, all zeros, alternating bits and a single edge, which expose off-by-one faults in the pair range and in the zero count. The random cases read the seed, step the LFSR, then run other operations in between to confirm that the state holds.

// File: rtl/alu_pkg.sv
package alu_pkg;
   typedef enum logic [3:0] {
      OP_ADD   = 4'd0,
      OP_SUB   = 4'd1,
      OP_SHR   = 4'd2,
      OP_SHL   = 4'd3,
      OP_ROR   = 4'd4,
      OP_ROL   = 4'd5,
      OP_ONES  = 4'd6,
      OP_ZEROS = 4'd7,
      OP_TRANS = 4'd8,
      OP_RAND  = 4'd9,
      OP_OR    = 4'd10,
      OP_AND   = 4'd11,
      OP_XOR   = 4'd12,
      OP_NOT   = 4'd13,
      OP_RSV0  = 4'd14,
      OP_RSV1  = 4'd15
   } alu_op_e;

   // bit-count flavours chosen per instance
   localparam int CNT_ONES  = 0;
   localparam int CNT_ZEROS = 1;
   localparam int CNT_TRANS = 2;
   localparam int CNT_KINDS = 3;
endpackage

// File: rtl/alu_shift.sv
module alu_shift #(
   parameter int W = 32,
   localparam int SW = $clog2(W)
) (
   input  logic [W-1:0]  val_i,
   input  logic [SW-1:0] amt_i,
   input  logic          left_i,
   input  logic          rot_i,
   output logic [W-1:0]  res_o
);
   // one stage per amount bit; stage s moves by 2**s
   logic [SW:0][W-1:0] stage;
   assign stage[0] = val_i;

   for (genvar s = 0; s < SW; s++) begin : g_stage
      localparam int K = 1 << s;
      logic [W-1:0] to_r, to_l;
      assign to_r = {(rot_i ? stage[s][K-1:0] : {K{1'b0}}), stage[s][W-1:K]};
      assign to_l = {stage[s][W-1-K:0], (rot_i ? stage[s][W-1:W-K] : {K{1'b0}})};
      assign stage[s+1] = amt_i[s] ? (left_i ? to_l : to_r) : stage[s];
   end

   assign res_o = stage[SW];
endmodule

// File: rtl/alu_bitcount.sv
module alu_bitcount #(
   parameter int W    = 32,
   parameter int KIND = 0,
   localparam int CW  = $clog2(W + 1)
) (
   input  logic [W-1:0]  val_i,
   output logic [CW-1:0] cnt_o
);
   function automatic logic [CW-1:0] ones(input logic [W-1:0] v);
      logic [CW-1:0] acc;
      acc = '0;
      for (int i = 0; i < W; i++) acc = acc + CW'(v[i]);
      return acc;
   endfunction

   if (KIND == alu_pkg::CNT_ONES) begin : g_ones
      assign cnt_o = ones(val_i);
   end else if (KIND == alu_pkg::CNT_ZEROS) begin : g_zeros
      assign cnt_o = CW'(W) - ones(val_i);
   end else if (KIND == alu_pkg::CNT_TRANS) begin : g_trans
      logic [W-1:0] edges;
      assign edges = {1'b0, val_i[W-1:1] ^ val_i[W-2:0]};
      assign cnt_o = ones(edges);
   end else begin : g_bad
      $error("alu_bitcount: unknown KIND %0d", KIND);
      assign cnt_o = '0;
   end
endmodule

// File: rtl/alu_lfsr.sv
module alu_lfsr #(
   parameter int         W    = 32,
   parameter logic [W-1:0] SEED = 32'h1D87_2B41,
   parameter logic [W-1:0] TAPS = 32'h8020_0003
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step_i,
   output logic [W-1:0] state_o
);
   logic [W-1:0] st, nxt;

   assign nxt = (st >> 1) ^ (st[0] ? TAPS : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      st <= SEED;
      else if (step_i) st <= nxt;
   end

   assign state_o = st;
endmodule

// File: rtl/alu_core.sv
module alu_core #(
   parameter int           W     = 32,
   parameter int           IMM_W = 16,
   parameter logic [W-1:0] SEED  = 32'h1D87_2B41,
   parameter logic [W-1:0] TAPS  = 32'h8020_0003
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       op_i,
   input  logic [W-1:0]     a_i,
   input  logic [W-1:0]     b_i,
   input  logic [IMM_W-1:0] imm_i,
   input  logic             use_imm_i,
   output logic [W-1:0]     res_o,
   output logic             carry_o,
   output logic             zero_o
);
   import alu_pkg::*;

   localparam int SW = $clog2(W);
   localparam int CW = $clog2(W + 1);

   if ((1 << SW) != W) begin : g_chk_pow2
      $error("alu_core: W=%0d must be a power of two", W);
   end
   if (IMM_W > W) begin : g_chk_imm
      $error("alu_core: IMM_W wider than W");
   end
   if (SEED == '0) begin : g_chk_seed
      $error("alu_core: LFSR seed must be non-zero");
   end
   if (!TAPS[W-1]) begin : g_chk_taps
      $error("alu_core: LFSR taps need the top bit");
   end

   alu_op_e op;
   assign op = alu_op_e'(op_i);

   logic [W-1:0] b_eff;
   assign b_eff = use_imm_i ? W'(imm_i) : b_i;

   // add / subtract share the operand path
   logic [W:0] sum, dif;
   assign sum = {1'b0, a_i} + {1'b0, b_eff};
   assign dif = {1'b0, a_i} - {1'b0, b_eff};

   logic [W-1:0] sh_res;
   alu_shift #(.W(W)) u_shift (
      .val_i  (a_i),
      .amt_i  (b_eff[SW-1:0]),
      .left_i (op == OP_SHL || op == OP_ROL),
      .rot_i  (op == OP_ROR || op == OP_ROL),
      .res_o  (sh_res)
   );

   logic [CNT_KINDS-1:0][CW-1:0] cnt;
   for (genvar k = 0; k < CNT_KINDS; k++) begin : g_cnt
      alu_bitcount #(.W(W), .KIND(k)) u_cnt (
         .val_i (a_i),
         .cnt_o (cnt[k])
      );
   end

   logic [W-1:0] rnd;
   alu_lfsr #(.W(W), .SEED(SEED), .TAPS(TAPS)) u_lfsr (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_i  (op == OP_RAND),
      .state_o (rnd)
   );

   always_comb begin
      carry_o = 1'b0;
      case (op)
         OP_ADD:   begin res_o = sum[W-1:0]; carry_o = sum[W];  end
         OP_SUB:   begin res_o = dif[W-1:0]; carry_o = ~dif[W]; end
         OP_SHR, OP_SHL, OP_ROR, OP_ROL: res_o = sh_res;
         OP_ONES:  res_o = W'(cnt[CNT_ONES]);
         OP_ZEROS: res_o = W'(cnt[CNT_ZEROS]);
         OP_TRANS: res_o = W'(cnt[CNT_TRANS]);
         OP_RAND:  res_o = rnd;
         OP_OR:    res_o = a_i | b_eff;
         OP_AND:   res_o = a_i & b_eff;
         OP_XOR:   res_o = a_i ^ b_eff;
         OP_NOT:   res_o = ~a_i;
         default:  res_o = '0;
      endcase
   end

   assign zero_o = (res_o == '0);
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
   parameter int W     = 32,
   parameter int IMM_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [3:0]       op_i,
   input logic [W-1:0]     a_i,
   input logic [W-1:0]     b_i,
   input logic [IMM_W-1:0] imm_i,
   input logic             use_imm_i,
   input logic [W-1:0]     res_o,
   input logic             carry_o,
   input logic             zero_o
);
   logic [W-1:0] b_sel;
   assign b_sel = use_imm_i ? W'(imm_i) : b_i;

   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   a_r1_add_sum: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 4'd0) |-> ({carry_o, res_o} == ({1'b0, a_i} + {1'b0, b_sel})));

   a_r2_sub_borrow: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 4'd1) |-> (carry_o == (a_i >= b_sel)));

   a_r3_imm_add: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 4'd0 && use_imm_i) |-> (res_o == a_i + W'(imm_i)));

   a_r6_count_range: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 4'd6 || op_i == 4'd7 || op_i == 4'd8) |-> (res_o <= W));

   a_r9_rand_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 4'd9) |-> (res_o != '0));

   a_r9_rand_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(op_i) == 4'd9 && op_i == 4'd9) |-> (res_o != $past(res_o)));

   a_r10_not: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 4'd13) |-> (res_o == ~a_i));

   a_r11_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i >= 4'd14) |-> (res_o == '0 && zero_o));

   a_r12_carry_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i > 4'd1) |-> !carry_o);
endmodule

bind alu_core alu_core_chk #(.W(W), .IMM_W(IMM_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_i      (op_i),
   .a_i       (a_i),
   .b_i       (b_i),
   .imm_i     (imm_i),
   .use_imm_i (use_imm_i),
   .res_o     (res_o),
   .carry_o   (carry_o),
   .zero_o    (zero_o)
);

// File: tb/alu_core_test.sv
module alu_core_test;
   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op_i = 4'd0;
   logic [31:0] a_i = '0, b_i = '0;
   logic [15:0] imm_i = '0;
   logic        use_imm_i = 1'b0;
   logic [31:0] res_o;
   logic        carry_o, zero_o;

   alu_core uut (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
      .imm_i(imm_i), .use_imm_i(use_imm_i),
      .res_o(res_o), .carry_o(carry_o), .zero_o(zero_o)
   );

   always #(PERIOD/2) clk = ~clk;

   int checks = 0, fails = 0;
   bit done = 0;
   logic [31:0] model_rnd = 32'h1D87_2B41;

   logic [33:0] q_exp[$];
   string       q_tag[$];

   function automatic logic [33:0] predict(input logic [3:0] op, input logic [31:0] a,
                                           input logic [31:0] b, input logic [31:0] rnd);
      logic [32:0] wide;
      logic [63:0] dbl;
      logic [31:0] r;
      logic c;
      int n;
      c = 1'b0;
      n = int'(b[4:0]);
      dbl = {a, a};
      case (op)
         4'd0: begin wide = {1'b0, a} + {1'b0, b}; r = wide[31:0]; c = wide[32]; end
         4'd1: begin r = a - b; c = (a >= b); end
         4'd2: r = a >> n;
         4'd3: r = a << n;
         4'd4: begin dbl = dbl >> n; r = dbl[31:0]; end
         4'd5: begin dbl = dbl << n; r = dbl[63:32]; end
         4'd6: begin r = 0; for (int i = 0; i < 32; i++) if (a[i]) r++; end
         4'd7: begin r = 0; for (int i = 0; i < 32; i++) if (!a[i]) r++; end
         4'd8: begin r = 0; for (int i = 0; i < 31; i++) if (a[i] != a[i+1]) r++; end
         4'd9: r = rnd;
         4'd10: r = a | b;
         4'd11: r = a & b;
         4'd12: r = a ^ b;
         4'd13: r = ~a;
         default: r = 0;
      endcase
      return {c, (r == 0), r};
   endfunction

   task automatic run(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                      input logic [15:0] imm, input logic use_imm, input string tag);
      logic [31:0] beff;
      @(negedge clk);
      op_i = op; a_i = a; b_i = b; imm_i = imm; use_imm_i = use_imm;
      beff = use_imm ? {16'h0000, imm} : b;
      q_exp.push_back(predict(op, a, beff, model_rnd));
      q_tag.push_back(tag);
      if (op == 4'd9)
         model_rnd = (model_rnd >> 1) ^ (model_rnd[0] ? 32'h8020_0003 : 32'h0);
   endtask

   // monitor: compare each result a quarter period after it was driven
   initial begin
      forever begin
         @(negedge clk);
         #(PERIOD/4);
         if (q_exp.size() > 0) begin
            logic [33:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            checks++;
            if ({carry_o, zero_o, res_o} !== e) begin
               fails++;
               $display("FAIL %s: got res=%h c=%b z=%b, expected res=%h c=%b z=%b",
                        t, res_o, carry_o, zero_o, e[31:0], e[33], e[32]);
            end
         end
      end
   end

   initial begin
      #(PERIOD * 100000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9 reset state, then stepping and holding
      run(4'd9, 0, 0, 0, 0, "R9 seed after reset");
      run(4'd9, 0, 0, 0, 0, "R9 first step");
      run(4'd0, 32'd5, 32'd7, 0, 0, "R1 add small");
      run(4'd9, 0, 0, 0, 0, "R9 held across add");
      run(4'd9, 0, 0, 0, 0, "R9 another step");
      // R1 / R12 add carry and zero
      run(4'd0, 32'hFFFF_FFFF, 32'd1, 0, 0, "R1 R12 add wraps to zero");
      run(4'd0, 32'h8000_0000, 32'h8000_0001, 0, 0, "R1 add carry out");
      // R2 subtract
      run(4'd1, 32'd10, 32'd3, 0, 0, "R2 sub no borrow");
      run(4'd1, 32'd3, 32'd10, 0, 0, "R2 sub borrow");
      run(4'd1, 32'd5, 32'd5, 0, 0, "R2 R12 sub equal");
      // R3 immediate select
      run(4'd0, 32'd1, 32'hFFFF_FFFF, 16'hFFFF, 1, "R3 imm add ignores b_i");
      run(4'd1, 32'h0002_0000, 32'd0, 16'h8000, 1, "R3 imm sub");
      run(4'd10, 32'h0, 32'hFFFF_0000, 16'h00F0, 1, "R3 imm or zero-extended");
      // R4 shifts
      run(4'd2, 32'h8000_0001, 32'd4, 0, 0, "R4 shr");
      run(4'd3, 32'h0000_00FF, 32'h0000_0024, 0, 0, "R4 shl amount masked");
      run(4'd3, 32'h0000_0003, 32'd31, 0, 0, "R4 shl by 31");
      // R5 rotates
      run(4'd4, 32'h0000_0001, 32'd1, 0, 0, "R5 ror wraps");
      run(4'd5, 32'h8000_0000, 32'd1, 0, 0, "R5 rol wraps");
      run(4'd4, 32'h1234_5678, 32'h0000_0020, 0, 0, "R5 ror amount 0");
      run(4'd5, 32'h1234_5678, 32'd12, 0, 0, "R5 rol by 12");
      // R6 R7 R8 counts
      run(4'd6, 32'hFFFF_FFFF, 0, 0, 0, "R6 ones all set");
      run(4'd6, 32'h0000_0000, 0, 0, 0, "R6 R12 ones none");
      run(4'd7, 32'h0000_0000, 0, 0, 0, "R7 zeros all clear");
      run(4'd7, 32'h0000_F0F0, 0, 0, 0, "R7 zeros mixed");
      run(4'd8, 32'hAAAA_AAAA, 0, 0, 0, "R8 transitions alternating");
      run(4'd8, 32'hFFFF_0000, 0, 0, 0, "R8 single edge");
      run(4'd8, 32'h8000_0001, 0, 0, 0, "R8 ends only");
      // R10 logic
      run(4'd10, 32'hF0F0_0000, 32'h0F0F_0000, 0, 0, "R10 or");
      run(4'd11, 32'hF0F0_FFFF, 32'h0F0F_0000, 0, 0, "R10 R12 and zero");
      run(4'd12, 32'hFFFF_0000, 32'hF0F0_F0F0, 0, 0, "R10 xor");
      run(4'd13, 32'hFFFF_FFFF, 32'h1234_5678, 0, 0, "R10 not");
      // R11 reserved, R12 carry clear
      run(4'd14, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, "R11 code 14");
      run(4'd15, 32'h1234_5678, 32'h1, 0, 0, "R11 code 15");
      run(4'd2, 32'hFFFF_FFFF, 32'd0, 0, 0, "R12 carry clear on shift");
      run(4'd9, 0, 0, 0, 0, "R9 state kept after other ops");
      @(negedge clk);
      op_i = 4'd0;
      #(PERIOD/2);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule